// File: doc/BRIEF.md
# Throughput-Driven Cipher Configuration Selector

This block picks an operating point for a pipelined block cipher. There are eight characterised operating points. Each one is a pipeline depth of 1, 2, 4 or 8 combined with one or two key generators. Each point has a fixed maximum throughput, held inside the block as an unsigned fixed-point value in tenths of a unit.

When a new bandwidth requirement arrives with a valid strobe, the selector latches it together with the ID of the configuration now running. It then walks an internal ranking, one entry per clock, and stops at the first entry that can meet the requirement. It reports the chosen ID, whether that choice is faster than the present one, and whether the requirement exceeds everything available. A one-cycle reconfigure pulse fires only when the chosen ID differs from the present ID.

The elaboration parameter `POLICY` selects the ranking:
- `POLICY` = 0 ranks all eight points by ascending throughput, so the block picks the cheapest point that meets the requirement.
- `POLICY` = 1 ranks only the two-generator points, which are the more energy-efficient family, so the search is at most four steps long.

The controller has three states, `ST_IDLE`, `ST_SCAN` and `ST_REPORT`, with these transitions:
- `ST_IDLE` to `ST_SCAN` on a valid strobe (accept).
- `ST_SCAN` to `ST_SCAN` while the examined entry falls short and is not the last entry (advance).
- `ST_SCAN` to `ST_REPORT` on a hit, or on reaching the last entry (settle).
- `ST_REPORT` to `ST_IDLE` unconditionally (publish, which loads the outputs).

Top module: `thr_cfg_sel`

## Requirements
- R1: After reset, `cfg_out` = 0, and `reconf_pulse`, `go_faster` and `bw_short` are all 0.
- R2: The maximum throughputs in tenths are 16, 34, 51, 81 for IDs 0 to 3 and 24, 60, 71, 98 for IDs 4 to 7. Bit 2 of an ID set means two key generators. Bits 1:0 give the depth as 1 shifted left by their value.
- R3: With `POLICY` = 0, the chosen ID is the one of lowest throughput whose throughput is at least `bw_req`, using an unsigned comparison. The search order is 0, 4, 1, 2, 5, 6, 3, 7.
- R4: With `POLICY` = 1, the chosen ID is the lowest-throughput ID among 4 to 7 that meets `bw_req`. The search order is 4, 5, 6, 7.
- R5: If no ranked entry meets `bw_req`, `cfg_out` = 7 and `bw_short` = 1. Otherwise `bw_short` = 0. A requirement equal to 98 is met.
- R6: `reconf_pulse` is high for exactly one cycle per decision, and only when the chosen ID differs from the latched `cur_cfg`.
- R7: `go_faster` is 1 when the chosen ID's throughput exceeds that of the latched `cur_cfg`, and 0 otherwise.
- R8: A strobe accepted at clock edge E updates the outputs at edge E+k+2, where k is the chosen entry's 0-based position in the search order.
- R9: `bw_valid` is ignored while a decision is in progress, including the report cycle.
- R10: `cfg_out`, `go_faster` and `bw_short` hold their values between decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bw_valid | input | 1 | Requirement strobe |
| bw_req | input | BW_W | Required throughput in tenths |
| cur_cfg | input | 3 | ID of the configuration now running |
| cfg_out | output | 3 | Chosen configuration ID |
| reconf_pulse | output | 1 | One-cycle reconfigure request |
| go_faster | output | 1 | Chosen point is faster than the current one |
| bw_short | output | 1 | Requirement exceeds the best available point |

## Verification
The bench builds two instances with `BW_W` = 8, one with `POLICY` = 0 and one with `POLICY` = 1, and drives both with the same stimulus. This exposes both search orders, from the shortest latency (k = 0) to the longest (k = 7 and k = 3). The 8-bit request width reaches values above 98, up to 255, which exercises saturation and the exact boundary at 98. It also exercises thresholds that fall exactly on a table value, such as 16 and 60. Strobes issued back to back while a decision is in progress test that busy strobes are ignored.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int NUM_CFG = 8;
    localparam int ID_W    = 3;
    localparam int THR_W   = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_REPORT
    } sel_state_t;

    // Maximum throughput of a configuration, in tenths of a unit.
    function automatic int cfg_thr(input int id);
        int t;
        unique case (id)
            0: t = 16;
            1: t = 34;
            2: t = 51;
            3: t = 81;
            4: t = 24;
            5: t = 60;
            6: t = 71;
            default: t = 98;
        endcase
        return t;
    endfunction

    // Two key generators when the top ID bit is set.
    function automatic bit cfg_dual(input int id);
        return id >= (NUM_CFG / 2);
    endfunction

    // Position of a configuration in the search order of a policy.
    // Configurations outside the policy get a position past the end.
    function automatic int rank_pos(input int policy, input int id);
        int p;
        if (policy == 1 && !cfg_dual(id))
            return NUM_CFG + id;
        p = 0;
        for (int j = 0; j < NUM_CFG; j++) begin
            if ((policy == 0 || cfg_dual(j)) && cfg_thr(j) < cfg_thr(id))
                p++;
        end
        return p;
    endfunction

endpackage

// File: rtl/tcs_thr_rom.sv
module tcs_thr_rom #(
    parameter int ID_W  = tcs_pkg::ID_W,
    parameter int THR_W = tcs_pkg::THR_W
) (
    input  logic [ID_W-1:0]  id,
    output logic [THR_W-1:0] thr
);
    always_comb begin
        thr = THR_W'(tcs_pkg::cfg_thr(int'(id)));
    end
endmodule

// File: rtl/tcs_rank_map.sv
module tcs_rank_map #(
    parameter int POLICY  = 0,
    parameter int NUM_CFG = tcs_pkg::NUM_CFG,
    parameter int ID_W    = tcs_pkg::ID_W,
    parameter int RANK_W  = $clog2(tcs_pkg::NUM_CFG)
) (
    input  logic [RANK_W-1:0] rank,
    output logic [ID_W-1:0]   id
);
    logic [NUM_CFG-1:0] hit;

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_pos
        localparam int POS = tcs_pkg::rank_pos(POLICY, i);
        assign hit[i] = (int'(rank) == POS);
    end

    always_comb begin
        id = '0;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (hit[i])
                id = id | ID_W'(i);
        end
    end

    always_comb begin
        AST_RANK_UNIQUE: assert ($onehot0(hit)); // R2
    end
endmodule

// File: rtl/thr_cfg_sel.sv
module thr_cfg_sel #(
    parameter int BW_W   = 8,
    parameter int POLICY = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bw_valid,
    input  logic [BW_W-1:0]          bw_req,
    input  logic [tcs_pkg::ID_W-1:0] cur_cfg,
    output logic [tcs_pkg::ID_W-1:0] cfg_out,
    output logic                     reconf_pulse,
    output logic                     go_faster,
    output logic                     bw_short
);
    import tcs_pkg::*;

    localparam int NUM_RANK  = (POLICY == 1) ? NUM_CFG / 2 : NUM_CFG;
    localparam int RANK_W    = $clog2(NUM_CFG);
    localparam int LAST_RANK = NUM_RANK - 1;
    localparam int CMP_W     = (BW_W > THR_W) ? BW_W : THR_W;

    sel_state_t        state, nxt;
    logic [BW_W-1:0]   req_q;
    logic [ID_W-1:0]   cur_q;
    logic [ID_W-1:0]   pick_q;
    logic              miss_q;
    logic [RANK_W-1:0] rank_q;

    logic [ID_W-1:0]   scan_id;
    logic [THR_W-1:0]  scan_thr, cur_thr, pick_thr;
    logic              meets, at_last;

    tcs_rank_map #(.POLICY(POLICY), .NUM_CFG(NUM_CFG), .ID_W(ID_W), .RANK_W(RANK_W)) u_rank (
        .rank (rank_q),
        .id   (scan_id)
    );

    tcs_thr_rom #(.ID_W(ID_W), .THR_W(THR_W)) u_rom_scan (.id(scan_id), .thr(scan_thr));
    tcs_thr_rom #(.ID_W(ID_W), .THR_W(THR_W)) u_rom_cur  (.id(cur_q),   .thr(cur_thr));
    tcs_thr_rom #(.ID_W(ID_W), .THR_W(THR_W)) u_rom_pick (.id(pick_q),  .thr(pick_thr));

    assign meets   = CMP_W'(scan_thr) >= CMP_W'(req_q);
    assign at_last = (rank_q == RANK_W'(LAST_RANK));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions: accept, advance, settle, publish
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (bw_valid) nxt = ST_SCAN;
            ST_SCAN:   if (meets || at_last) nxt = ST_REPORT;
            ST_REPORT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Request capture and search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= '0;
            cur_q  <= '0;
            rank_q <= '0;
            pick_q <= '0;
            miss_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (bw_valid) begin
                        req_q  <= bw_req;
                        cur_q  <= cur_cfg;
                        rank_q <= '0;
                    end
                end
                ST_SCAN: begin
                    if (meets || at_last) begin
                        pick_q <= scan_id;
                        miss_q <= !meets;
                    end else begin
                        rank_q <= rank_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_out      <= '0;
            reconf_pulse <= 1'b0;
            go_faster    <= 1'b0;
            bw_short     <= 1'b0;
        end else if (state == ST_REPORT) begin
            cfg_out      <= pick_q;
            bw_short     <= miss_q;
            reconf_pulse <= (pick_q != cur_q);
            go_faster    <= (pick_thr > cur_thr);
        end else begin
            reconf_pulse <= 1'b0;
        end
    end

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_pulse |=> !reconf_pulse); // R6
    AST_PULSE_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_pulse |-> (cfg_out != cur_q)); // R6
    AST_SHORT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        bw_short |-> (cfg_out == ID_W'(NUM_CFG - 1))); // R5
    AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(req_q) && $stable(cur_q))); // R9
    AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |-> (rank_q <= RANK_W'(LAST_RANK))); // R8
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_REPORT) |=> ($stable(cfg_out) && $stable(go_faster) && $stable(bw_short))); // R10

    if (POLICY == 1) begin : g_dual_chk
        AST_DUAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            reconf_pulse |-> cfg_out[ID_W-1]); // R4
    end
endmodule

// File: tb/thr_cfg_sel_test.sv
module thr_cfg_sel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bw_valid = 1'b0;
    logic [7:0] bw_req = '0;
    logic [2:0] cur_cfg = '0;

    logic [2:0] o_id [2];
    logic       o_pulse [2];
    logic       o_fast [2];
    logic       o_short [2];

    int checks = 0;
    int bad = 0;

    always #10 clk = ~clk;

    thr_cfg_sel #(.BW_W(8), .POLICY(0)) uut (
        .clk(clk), .rst_n(rst_n), .bw_valid(bw_valid), .bw_req(bw_req), .cur_cfg(cur_cfg),
        .cfg_out(o_id[0]), .reconf_pulse(o_pulse[0]), .go_faster(o_fast[0]), .bw_short(o_short[0])
    );
    thr_cfg_sel #(.BW_W(8), .POLICY(1)) uut_e (
        .clk(clk), .rst_n(rst_n), .bw_valid(bw_valid), .bw_req(bw_req), .cur_cfg(cur_cfg),
        .cfg_out(o_id[1]), .reconf_pulse(o_pulse[1]), .go_faster(o_fast[1]), .bw_short(o_short[1])
    );

    function automatic int thr_of(input int id);
        case (id)
            0: return 16;  1: return 34;  2: return 51;  3: return 81;
            4: return 24;  5: return 60;  6: return 71;  default: return 98;
        endcase
    endfunction

    function automatic void ref_pick(input int pol, input int req,
                                     output int id, output int k, output bit sh);
        id = -1;
        for (int j = 0; j < 8; j++)
            if ((pol == 0 || j >= 4) && thr_of(j) >= req && (id < 0 || thr_of(j) < thr_of(id)))
                id = j;
        sh = 1'b0;
        if (id < 0) begin id = 7; sh = 1'b1; end
        k = 0;
        for (int j = 0; j < 8; j++)
            if ((pol == 0 || j >= 4) && thr_of(j) < thr_of(id))
                k++;
    endfunction

    // Behavioural reference: countdown to the publish edge
    int m_cnt [2], p_id [2], p_cur [2];
    bit p_sh [2];
    int e_id [2];
    bit e_pulse [2], e_fast [2], e_sh [2];
    int pulses [2];

    always @(posedge clk) begin
        for (int m = 0; m < 2; m++) begin
            if (!rst_n) begin
                m_cnt[m] = 0; e_id[m] = 0; e_pulse[m] = 0; e_fast[m] = 0; e_sh[m] = 0;
            end else begin
                e_pulse[m] = 0;
                if (m_cnt[m] > 0) begin
                    m_cnt[m]--;
                    if (m_cnt[m] == 0) begin
                        e_id[m]    = p_id[m];
                        e_sh[m]    = p_sh[m];
                        e_pulse[m] = (p_id[m] != p_cur[m]);
                        e_fast[m]  = thr_of(p_id[m]) > thr_of(p_cur[m]);
                    end
                end else if (bw_valid) begin
                    int id, k;
                    bit sh;
                    ref_pick(m, int'(bw_req), id, k, sh);
                    p_id[m] = id; p_sh[m] = sh; p_cur[m] = int'(cur_cfg);
                    m_cnt[m] = k + 2;
                end
            end
        end
    end

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            for (int m = 0; m < 2; m++) begin
                if (o_pulse[m]) pulses[m]++;
                checks++;
                if (int'(o_id[m]) != e_id[m]) begin
                    bad++;
                    $display("FAIL R8 R10 inst%0d cfg_out got %0d exp %0d", m, o_id[m], e_id[m]);
                end
                checks++;
                if (o_pulse[m] != e_pulse[m]) begin
                    bad++;
                    $display("FAIL R6 inst%0d reconf_pulse got %0d exp %0d", m, o_pulse[m], e_pulse[m]);
                end
                checks++;
                if (o_fast[m] != e_fast[m]) begin
                    bad++;
                    $display("FAIL R7 inst%0d go_faster got %0d exp %0d", m, o_fast[m], e_fast[m]);
                end
                checks++;
                if (o_short[m] != e_sh[m]) begin
                    bad++;
                    $display("FAIL R5 inst%0d bw_short got %0d exp %0d", m, o_short[m], e_sh[m]);
                end
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    // Issue one request, wait for both decisions, check against literal expectations
    task automatic run_req(input int req, input int cur, input int x0, input int x1,
                           input bit xs, input string tag);
        int pc0, pc1;
        pc0 = pulses[0]; pc1 = pulses[1];
        @(negedge clk);
        bw_valid = 1'b1; bw_req = 8'(req); cur_cfg = 3'(cur);
        @(negedge clk);
        bw_valid = 1'b0;
        repeat (12) @(negedge clk);
        chk({tag, " pol0 id"}, int'(o_id[0]), x0);
        chk({tag, " pol1 id"}, int'(o_id[1]), x1);
        chk("R5 short pol0", int'(o_short[0]), int'(xs));
        chk("R6 pulse count pol0", pulses[0] - pc0, (x0 != cur) ? 1 : 0);
        chk("R6 pulse count pol1", pulses[1] - pc1, (x1 != cur) ? 1 : 0);
        chk("R7 faster pol1", int'(o_fast[1]), (thr_of(x1) > thr_of(cur)) ? 1 : 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cfg_out", int'(o_id[0]), 0);
        chk("R1 pulse", int'(o_pulse[0]), 0);
        chk("R1 faster", int'(o_fast[1]), 0);
        chk("R1 short", int'(o_short[1]), 0);
        rst_n = 1'b1;

        run_req(0,   0, 0, 4, 0, "R3 R4 zero");
        run_req(16,  0, 0, 4, 0, "R2 R3 exact 16");
        run_req(17,  3, 4, 4, 0, "R2 R3 just above 16");
        run_req(30,  7, 1, 5, 0, "R3 R4 req 30");
        run_req(60,  1, 5, 5, 0, "R2 R4 exact 60");
        run_req(61,  5, 6, 6, 0, "R3 R4 req 61");
        run_req(72,  6, 3, 7, 0, "R3 R4 req 72");
        run_req(98,  7, 7, 7, 0, "R5 boundary 98");
        run_req(99,  0, 7, 7, 1, "R5 saturate 99");
        run_req(255, 7, 7, 7, 1, "R5 saturate 255");
        run_req(10,  7, 0, 4, 0, "R7 slower");

        // R9: second strobe while busy is ignored
        @(negedge clk);
        bw_valid = 1'b1; bw_req = 8'd99; cur_cfg = 3'd0;
        @(negedge clk);
        bw_req = 8'd0;
        @(negedge clk);
        bw_valid = 1'b0;
        repeat (12) @(negedge clk);
        chk("R9 busy strobe ignored pol0", int'(o_id[0]), 7);
        chk("R9 busy strobe ignored pol1", int'(o_id[1]), 7);

        // Random traffic, compared every cycle by the reference
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            bw_valid = ($urandom_range(0, 2) != 0);
            bw_req   = 8'($urandom_range(0, 120));
            cur_cfg  = 3'($urandom_range(0, 7));
        end
        bw_valid = 1'b0;
        repeat (15) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule